// File: doc/BRIEF.md
# Answer-to-Reset Structure Parser

This block sits behind a smart card character receiver and consumes the decoded bytes that follow the initial synchronisation character of a card's answer to reset. It works out the role of every byte without a fixed length. The format byte's upper nibble and each protocol-group byte's upper nibble chain together presence masks for the interface bytes. The format byte's lower nibble counts the historical bytes. A closing check byte is required only when a protocol other than type 0 has been offered.

While the bytes go past, the block captures the clock-rate code and the bit-rate code from the first group and turns them into the conversion factors F and D through a lookup table. It also captures the extra guard time from the first group and builds a bitmap of the protocol types offered. When the answer is complete it raises done. It flags a failed exclusive-or check, an answer that runs past the size limit, and a reserved rate code. A restart pulse clears everything so that a new answer can be parsed. The factors are only reported; changing the line rate is left to the surrounding logic.

Top module: `atr_parser`

## Requirements
- R1: After reset, done, chk_err, ovf_err and param_err are 0, f_factor is 372, d_factor is 1, guard_n is 0 and proto_mask is 16'h0001 (type 0 implied).
- R2: The first byte after reset or restart is the format byte. Its bits 4, 5, 6 and 7 announce the first-group bytes TA, TB, TC and TD, and bits 3:0 give the number of historical bytes (0 to 15).
- R3: Announced interface bytes of a group arrive in the order TA, TB, TC, TD. A TD byte's bits 7:4 announce the next group in the same bit order, and its bits 3:0 give a protocol type T, which sets bit T of proto_mask. If no TD byte is seen, proto_mask stays 16'h0001.
- R4: The first group's TA byte carries the clock-rate code in bits 7:4 and the bit-rate code in bits 3:0. Codes 1..6 give F = 372, 558, 744, 1116, 1488, 1860; codes 9..13 give F = 512, 768, 1024, 1536, 2048. Bit-rate codes 1..5 give D = 1, 2, 4, 8, 16.
- R5: A clock-rate code of 0, 7, 8, 14 or 15, or a bit-rate code of 0 or 6..15, sets param_err. The factor with the reserved code keeps its default (F=372 or D=1).
- R6: The first group's TC byte sets guard_n to its full value. TA or TC bytes of later groups change neither the factors nor guard_n.
- R7: A check byte follows the historical bytes exactly when some TD byte carried a nonzero T. done rises in the cycle after the last expected byte is accepted, and not before.
- R8: chk_err is set together with done when the exclusive-or of every byte from the format byte through the check byte is not zero.
- R9: A byte presented when 32 bytes have already been accepted and done is low sets ovf_err and done. That byte changes no reported parameter.
- R10: Once done is high, further bytes are ignored: every output keeps its value until restart.
- R11: A restart pulse returns every output to its R1 value. The next byte is then treated as a format byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous clear before a new answer; has priority over byte_valid |
| byte_valid | input | 1 | byte_data holds a decoded byte this cycle |
| byte_data | input | 8 | Decoded answer byte |
| done | output | 1 | Answer complete or aborted by overflow |
| chk_err | output | 1 | Check byte exclusive-or mismatch |
| ovf_err | output | 1 | Answer exceeded the byte limit |
| param_err | output | 1 | Reserved clock-rate or bit-rate code seen |
| f_factor | output | 12 | Clock rate conversion factor F |
| d_factor | output | 5 | Bit rate adjustment factor D |
| guard_n | output | 8 | Extra guard time N in elementary time units |
| proto_mask | output | 16 | Bit T set for each protocol type offered |

## Verification
The checker module checks, on every cycle, the invariants that hold regardless of byte content. done and every parameter output hold while done is high. Each error flag implies done. Overflow and checksum errors never appear together. The accepted-byte count stays within its limit. A restart clears the flags on the next cycle. Whether the parser assigns each byte its correct role can only be shown by the bench's scenarios. This covers where done lands in the stream, whether a check byte is demanded, which group's TA or TC takes effect, and what the lookup returns. The bench's scenarios feed chained presence masks, historical counts, corrupted check bytes and over-long answers, and compare the results with an independent walk of the same byte list.

// File: rtl/atr_pkg.sv
package atr_pkg;

    // Role of the byte expected next in the answer stream
    typedef enum logic [2:0] {
        K_FMT  = 3'd0,
        K_TA   = 3'd1,
        K_TB   = 3'd2,
        K_TC   = 3'd3,
        K_TD   = 3'd4,
        K_HIST = 3'd5,
        K_TCK  = 3'd6,
        K_END  = 3'd7
    } atr_kind_e;

    localparam int unsigned F_DEFAULT = 372;
    localparam int unsigned D_DEFAULT = 1;

    // Pick the role of the following byte: pending interface bytes in
    // A,B,C,D order first, then historical bytes, then the check byte.
    function automatic atr_kind_e pick_next(input logic [3:0] pend,
                                            input logic [3:0] hist,
                                            input logic       tck);
        atr_kind_e k;
        if (pend[0])          k = K_TA;
        else if (pend[1])     k = K_TB;
        else if (pend[2])     k = K_TC;
        else if (pend[3])     k = K_TD;
        else if (hist != 4'd0) k = K_HIST;
        else if (tck)         k = K_TCK;
        else                  k = K_END;
        return k;
    endfunction

endpackage

// File: rtl/atr_fd_lut.sv
module atr_fd_lut #(
    parameter int F_W = 12,
    parameter int D_W = 5
) (
    input  logic [3:0]     fi_code,
    input  logic [3:0]     di_code,
    output logic [F_W-1:0] f_val,
    output logic           f_ok,
    output logic [D_W-1:0] d_val,
    output logic           d_ok
);
    always_comb begin
        f_ok  = 1'b1;
        f_val = F_W'(atr_pkg::F_DEFAULT);
        case (fi_code)
            4'd1:    f_val = F_W'(372);
            4'd2:    f_val = F_W'(558);
            4'd3:    f_val = F_W'(744);
            4'd4:    f_val = F_W'(1116);
            4'd5:    f_val = F_W'(1488);
            4'd6:    f_val = F_W'(1860);
            4'd9:    f_val = F_W'(512);
            4'd10:   f_val = F_W'(768);
            4'd11:   f_val = F_W'(1024);
            4'd12:   f_val = F_W'(1536);
            4'd13:   f_val = F_W'(2048);
            default: f_ok  = 1'b0;
        endcase
    end

    // D doubles per code step over the defined range 1..5
    always_comb begin
        d_ok  = (di_code >= 4'd1) && (di_code <= 4'd5);
        d_val = D_W'(atr_pkg::D_DEFAULT);
        if (d_ok) d_val = D_W'(1) << (di_code - 4'd1);
    end
endmodule

// File: rtl/atr_seq.sv
module atr_seq #(
    parameter int MAX_BYTES = 32,
    localparam int CNT_W = $clog2(MAX_BYTES + 1),
    localparam int GRP_W = $clog2(MAX_BYTES + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                byte_valid,
    input  logic [7:0]          byte_data,
    output logic                use_byte,
    output atr_pkg::atr_kind_e  kind_o,
    output logic [GRP_W-1:0]    grp_o,
    output logic [CNT_W-1:0]    cnt_o,
    output logic                done_o,
    output logic                chk_err_o,
    output logic                ovf_err_o
);
    import atr_pkg::*;

    typedef struct packed {
        atr_kind_e        kind;
        logic [3:0]       pend;
        logic [3:0]       hist;
        logic             tck;
        logic [GRP_W-1:0] grp;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       acc;
        logic             done;
        logic             chk_err;
        logic             ovf_err;
    } seq_t;

    localparam seq_t SEQ_IDLE = '{kind: K_FMT, pend: 4'd0, hist: 4'd0, tck: 1'b0,
                                  grp: '0, cnt: '0, acc: 8'd0, done: 1'b0,
                                  chk_err: 1'b0, ovf_err: 1'b0};

    seq_t s_d, s_q;
    logic take, full;
    logic [3:0] pend_v, hist_v;
    logic tck_v;
    logic [GRP_W-1:0] grp_v;
    atr_kind_e nk;

    assign take = byte_valid && !s_q.done && !restart;
    assign full = (s_q.cnt == CNT_W'(MAX_BYTES));

    always_comb begin
        s_d    = s_q;
        pend_v = s_q.pend;
        hist_v = s_q.hist;
        tck_v  = s_q.tck;
        grp_v  = s_q.grp;
        nk     = K_END;
        if (restart) begin
            s_d = SEQ_IDLE;
        end else if (take && full) begin
            s_d.ovf_err = 1'b1;
            s_d.done    = 1'b1;
        end else if (take) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
            s_d.acc = s_q.acc ^ byte_data;
            case (s_q.kind)
                K_FMT: begin
                    pend_v = byte_data[7:4];
                    hist_v = byte_data[3:0];
                    grp_v  = GRP_W'(1);
                end
                K_TD: begin
                    pend_v = byte_data[7:4];
                    grp_v  = s_q.grp + GRP_W'(1);
                    if (byte_data[3:0] != 4'd0) tck_v = 1'b1;
                end
                K_HIST: hist_v = s_q.hist - 4'd1;
                K_TCK:  s_d.chk_err = ((s_q.acc ^ byte_data) != 8'd0);
                default: ;
            endcase
            nk = pick_next(pend_v, hist_v, tck_v);
            // consume the slot that has just been chosen
            case (nk)
                K_TA:  pend_v[0] = 1'b0;
                K_TB:  pend_v[1] = 1'b0;
                K_TC:  pend_v[2] = 1'b0;
                K_TD:  pend_v[3] = 1'b0;
                K_TCK: tck_v     = 1'b0;
                K_END: s_d.done  = 1'b1;
                default: ;
            endcase
            s_d.kind = nk;
            s_d.pend = pend_v;
            s_d.hist = hist_v;
            s_d.tck  = tck_v;
            s_d.grp  = grp_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_IDLE;
        else        s_q <= s_d;
    end

    assign use_byte  = take && !full;
    assign kind_o    = s_q.kind;
    assign grp_o     = s_q.grp;
    assign cnt_o     = s_q.cnt;
    assign done_o    = s_q.done;
    assign chk_err_o = s_q.chk_err;
    assign ovf_err_o = s_q.ovf_err;
endmodule

// File: rtl/atr_parser.sv
module atr_parser #(
    parameter int MAX_BYTES = 32,
    parameter int F_W = 12,
    parameter int D_W = 5,
    localparam int CNT_W = $clog2(MAX_BYTES + 1),
    localparam int GRP_W = $clog2(MAX_BYTES + 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           byte_valid,
    input  logic [7:0]     byte_data,
    output logic           done,
    output logic           chk_err,
    output logic           ovf_err,
    output logic           param_err,
    output logic [F_W-1:0] f_factor,
    output logic [D_W-1:0] d_factor,
    output logic [7:0]     guard_n,
    output logic [15:0]    proto_mask
);
    import atr_pkg::*;

    typedef struct packed {
        logic [F_W-1:0] f;
        logic [D_W-1:0] d;
        logic [7:0]     n;
        logic [15:0]    seen;
        logic           perr;
    } par_t;

    localparam par_t PAR_IDLE = '{f: F_W'(F_DEFAULT), d: D_W'(D_DEFAULT),
                                  n: 8'd0, seen: 16'd0, perr: 1'b0};

    logic             use_byte;
    atr_kind_e        kind;
    logic [GRP_W-1:0] grp;
    logic [CNT_W-1:0] byte_cnt;
    logic [F_W-1:0]   lut_f;
    logic [D_W-1:0]   lut_d;
    logic             lut_f_ok, lut_d_ok;
    logic             first_grp;
    par_t p_d, p_q;

    atr_seq #(.MAX_BYTES(MAX_BYTES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .byte_valid(byte_valid),
        .byte_data (byte_data),
        .use_byte  (use_byte),
        .kind_o    (kind),
        .grp_o     (grp),
        .cnt_o     (byte_cnt),
        .done_o    (done),
        .chk_err_o (chk_err),
        .ovf_err_o (ovf_err)
    );

    atr_fd_lut #(.F_W(F_W), .D_W(D_W)) u_lut (
        .fi_code(byte_data[7:4]),
        .di_code(byte_data[3:0]),
        .f_val  (lut_f),
        .f_ok   (lut_f_ok),
        .d_val  (lut_d),
        .d_ok   (lut_d_ok)
    );

    assign first_grp = (grp == GRP_W'(1));

    always_comb begin
        p_d = p_q;
        if (restart) begin
            p_d = PAR_IDLE;
        end else if (use_byte) begin
            case (kind)
                K_TA: if (first_grp) begin
                    if (lut_f_ok) p_d.f = lut_f; else p_d.perr = 1'b1;
                    if (lut_d_ok) p_d.d = lut_d; else p_d.perr = 1'b1;
                end
                K_TC: if (first_grp) p_d.n = byte_data;
                K_TD: p_d.seen[byte_data[3:0]] = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= PAR_IDLE;
        else        p_q <= p_d;
    end

    assign param_err  = p_q.perr;
    assign f_factor   = p_q.f;
    assign d_factor   = p_q.d;
    assign guard_n    = p_q.n;
    assign proto_mask = (p_q.seen == 16'd0) ? 16'h0001 : p_q.seen;
endmodule

// File: rtl/atr_parser_chk.sv
module atr_parser_chk #(
    parameter int MAX_BYTES = 32,
    parameter int F_W = 12,
    parameter int D_W = 5,
    localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           restart,
    input logic           done,
    input logic           chk_err,
    input logic           ovf_err,
    input logic           param_err,
    input logic [F_W-1:0] f_factor,
    input logic [D_W-1:0] d_factor,
    input logic [7:0]     guard_n,
    input logic [15:0]    proto_mask,
    input logic [CNT_W-1:0] byte_cnt
);
    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !restart |=> done);
    // R10
    outs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !restart |=> $stable(f_factor) && $stable(d_factor) &&
                             $stable(guard_n) && $stable(proto_mask) &&
                             $stable(chk_err) && $stable(param_err));
    // R8
    chk_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_err |-> done);
    // R9
    ovf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> done && !chk_err);
    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= CNT_W'(MAX_BYTES));
    // R11
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !done && !chk_err && !ovf_err && !param_err &&
                    proto_mask == 16'h0001);
    // R3
    proto_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_mask != 16'd0);
endmodule

bind atr_parser atr_parser_chk #(.MAX_BYTES(MAX_BYTES), .F_W(F_W), .D_W(D_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .done      (done),
    .chk_err   (chk_err),
    .ovf_err   (ovf_err),
    .param_err (param_err),
    .f_factor  (f_factor),
    .d_factor  (d_factor),
    .guard_n   (guard_n),
    .proto_mask(proto_mask),
    .byte_cnt  (byte_cnt)
);

// File: tb/tb_atr_parser.sv
module tb_atr_parser;
    localparam int MAXB = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'd0;
    logic        done, chk_err, ovf_err, param_err;
    logic [11:0] f_factor;
    logic [4:0]  d_factor;
    logic [7:0]  guard_n;
    logic [15:0] proto_mask;

    atr_parser dut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .byte_valid(byte_valid),
        .byte_data(byte_data), .done(done), .chk_err(chk_err), .ovf_err(ovf_err),
        .param_err(param_err), .f_factor(f_factor), .d_factor(d_factor),
        .guard_n(guard_n), .proto_mask(proto_mask)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] q [0:127];
    int qlen;

    // expected values
    int  e_len, e_feed;
    bit  e_chk, e_ovf, e_perr;
    int  e_f, e_d, e_n;
    logic [15:0] e_proto;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int f_of(input logic [3:0] c);
        case (c)
            4'd1: return 372;  4'd2: return 558;  4'd3: return 744;
            4'd4: return 1116; 4'd5: return 1488; 4'd6: return 1860;
            4'd9: return 512;  4'd10: return 768; 4'd11: return 1024;
            4'd12: return 1536; 4'd13: return 2048;
            default: return 0;
        endcase
    endfunction

    function automatic int d_of(input logic [3:0] c);
        if (c >= 4'd1 && c <= 4'd5) return 1 << (c - 1);
        return 0;
    endfunction

    // Walk the byte list as the requirements describe it
    task automatic analyze();
        int idx, g, k;
        logic [3:0] y;
        logic [7:0] v, x;
        bit nz;
        e_f = 372; e_d = 1; e_n = 0; e_perr = 0; e_proto = 16'd0; e_chk = 0;
        y = q[0][7:4]; k = q[0][3:0]; idx = 1; g = 1; nz = 0;
        while (y != 4'd0) begin
            logic [3:0] ny = 4'd0;
            for (int b = 0; b < 4; b++) begin
                if (y[b]) begin
                    v = q[idx];
                    if (idx < MAXB) begin
                        if (g == 1 && b == 0) begin
                            if (f_of(v[7:4]) == 0) e_perr = 1; else e_f = f_of(v[7:4]);
                            if (d_of(v[3:0]) == 0) e_perr = 1; else e_d = d_of(v[3:0]);
                        end
                        if (g == 1 && b == 2) e_n = v;
                        if (b == 3) e_proto[v[3:0]] = 1'b1;
                    end
                    if (b == 3) begin
                        ny = v[7:4];
                        if (v[3:0] != 4'd0) nz = 1;
                    end
                    idx++;
                end
            end
            y = ny; g++;
        end
        idx += k;
        if (nz) begin
            x = 8'd0;
            for (int i = 0; i <= idx; i++) x ^= q[i];
            e_chk = (x != 8'd0);
            idx++;
        end
        if (e_proto == 16'd0) e_proto = 16'h0001;
        e_len = idx;
        e_ovf = (e_len > MAXB);
        if (e_ovf) e_chk = 0;
        e_feed = e_ovf ? MAXB + 1 : e_len;
    endtask

    function automatic void push(input logic [7:0] b);
        q[qlen] = b;
        qlen++;
    endfunction

    task automatic build_random();
        logic [7:0] t0, v, x;
        logic [3:0] y, ny;
        int g;
        bit nz;
        qlen = 0; nz = 0; g = 1;
        t0 = 8'($urandom);
        push(t0);
        y = t0[7:4];
        while (y != 4'd0) begin
            ny = 4'd0;
            for (int b = 0; b < 4; b++) begin
                if (y[b]) begin
                    v = 8'($urandom);
                    if (b == 3) begin
                        if (($urandom % 3) != 0 || g > 6) v[7] = 1'b0;
                        if (($urandom % 2) == 0) v[3:0] = 4'd0;
                        ny = v[7:4];
                        if (v[3:0] != 4'd0) nz = 1;
                    end
                    push(v);
                end
            end
            y = ny; g++;
        end
        for (int i = 0; i < int'(t0[3:0]); i++) push(8'($urandom));
        if (nz) begin
            x = 8'd0;
            for (int i = 0; i < qlen; i++) x ^= q[i];
            if (($urandom % 4) == 0) x ^= 8'(1 + $urandom % 255);
            push(x);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        // R11: restart returns every output to its idle value
        check("R11 done", done, 0);
        check("R11 f", f_factor, 372);
        check("R11 proto", proto_mask, 1);
    endtask

    task automatic run_atr();
        analyze();
        do_restart();
        for (int i = 0; i < e_feed; i++) begin
            // R7: done not before the last expected byte
            if (i == e_feed - 1) check("R7 early done", done, 0);
            send(q[i]);
        end
        check("R7 done", done, 1);
        check("R8 chk_err", chk_err, e_chk);
        check("R9 ovf_err", ovf_err, e_ovf);
        check("R5 param_err", param_err, e_perr);
        check("R4 f_factor", f_factor, e_f);
        check("R4 d_factor", d_factor, e_d);
        check("R6 guard_n", guard_n, e_n);
        check("R3 proto_mask", proto_mask, e_proto);
        // R10: trailing bytes are ignored
        send(8'h5A); send(8'hF1);
        check("R10 done", done, 1);
        check("R10 f", f_factor, e_f);
        check("R10 proto", proto_mask, e_proto);
        check("R10 chk", chk_err, e_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 done", done, 0);
        check("R1 errs", {chk_err, ovf_err, param_err}, 0);
        check("R1 f", f_factor, 372);
        check("R1 d", d_factor, 1);
        check("R1 n", guard_n, 0);
        check("R1 proto", proto_mask, 1);

        // R2: empty format byte ends the answer at once
        qlen = 0; push(8'h00); run_atr();
        // R2 R4 R7: TA1/TD1 with T=0 only, two historical bytes, no check byte
        qlen = 0; push(8'h92); push(8'h94); push(8'h00); push(8'h11); push(8'h22);
        run_atr();
        // R8: T=1 offered, corrupted check byte
        qlen = 0; push(8'h80); push(8'h01); push(8'h33);
        run_atr();
        // R5: reserved codes
        qlen = 0; push(8'h10); push(8'h76); run_atr();
        qlen = 0; push(8'h10); push(8'hE0); run_atr();
        // R6: TA2 and TC2 must not touch parameters; TC1 sets N
        qlen = 0; push(8'hC0); push(8'h2A); push(8'hD1); push(8'h95); push(8'h77);
        push(8'h00); push(8'h2A ^ 8'hC0 ^ 8'hD1 ^ 8'h95 ^ 8'h77 ^ 8'h00 ^ 8'h00);
        q[6] = 8'hC0 ^ 8'h2A ^ 8'hD1 ^ 8'h95 ^ 8'h77 ^ 8'h00;
        run_atr();
        // R9: long chain of full groups overflows
        qlen = 0; push(8'hFF);
        for (int g = 0; g < 9; g++) begin
            push(8'h11); push(8'h22); push(8'h33); push(g < 8 ? 8'hF1 : 8'h01);
        end
        run_atr();
        // R3: random chained structures
        for (int t = 0; t < 60; t++) begin
            build_random();
            run_atr();
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule